// File: doc/BRIEF.md
# Single-precision normalize and round unit

This unit takes the unpacked result of a single-precision arithmetic step and turns it into a packed IEEE-754 binary32 word. Each input carries a sign, a signed unbiased exponent, a 32-bit fraction word and a 32-bit remainder word that holds the bits below the fraction LSB. The hidden one in the fraction word may sit anywhere. The unit finds the leading one across both words, shifts the pair so the hidden one lands at bit 23, and adjusts the exponent to match. It then rounds in one of four modes, handles overflow and tiny results with replacement values that depend on the mode, and reports raw overflow, underflow and inexact flags.

Tiny results are judged after rounding. When the rounded exponent falls below the normal range, the unrounded value is shifted right into denormal position and rounded a second time. A small valid/ready pipeline with a fixed latency of two accepted-to-output clock edges sits around the datapath.

Top module: `fp_norm_round`

## Requirements
- R1: The input value is frac_i·2^(exp_i−23) plus rem_i·2^(exp_i−55). exp_i is two's complement. When the leading one of {frac_i, rem_i} lies below bit 23 of frac_i, the pair is shifted left until it reaches bit 23, remainder bits move into the fraction, and the exponent is lowered by the shift.
- R2: When the leading one lies above bit 23, the pair is shifted right and the exponent is raised. Any one bit shifted out of the remainder is ORed into the remainder LSB, so inexactness is kept.
- R3: Mode 2'b00 rounds to nearest. The fraction is incremented when the remainder MSB is set. On an exact tie (remainder 0x80000000) the fraction LSB is then cleared.
- R4: Mode 2'b01 truncates the remainder.
- R5: Mode 2'b10 increments a positive value with a non-zero remainder and truncates a negative one. Mode 2'b11 does the reverse.
- R6: If rounding carries the 24-bit significand to 2^24, the exponent rises by one and the significand becomes 2^23.
- R7: A rounded exponent above 127 gives overflow and inexact. The result is infinity (exponent field 0xFF, fraction 0) in nearest mode, in mode 2'b10 when positive and in mode 2'b11 when negative. Otherwise the result is the largest finite value (field 0xFE, fraction 0x7FFFFF).
- R8: A rounded exponent below −126 means a tiny result. The unrounded significand and remainder are shifted right by (−126 − exponent), with sticky collection, rounded again in the active mode and packed with exponent field 0. A carry here yields field 1. Underflow and inexact are raised only when bits were discarded.
- R9: If that denormalizing shift is 25 or more, the result is zero with underflow and inexact. It becomes the smallest denormal (magnitude 1) only in mode 2'b10 with a positive sign or mode 2'b11 with a negative sign.
- R10: A normal result carries exponent field exp+127 and the low 23 significand bits. Inexact is raised exactly when the remainder was non-zero. Overflow and underflow stay low.
- R11: All-zero fraction and remainder words give a signed zero with no flag, whatever the exponent and mode.
- R12: After reset out_valid_o is low. An item accepted at one clock edge is presented after the next edge. While out_valid_o is high and out_ready_i is low, in_ready_o is low and the output holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input item present |
| in_ready_o | output | 1 | Unit can take an item this cycle |
| sign_i | input | 1 | Sign of the value |
| exp_i | input | 10 | Unbiased exponent, two's complement |
| frac_i | input | 32 | Fraction word, hidden one expected at bit 23 |
| rem_i | input | 32 | Bits below the fraction LSB |
| mode_i | input | 2 | Rounding mode (00 nearest, 01 zero, 10 up, 11 down) |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes the result |
| result_o | output | 32 | Packed binary32 result |
| overflow_o | output | 1 | Overflow indication |
| underflow_o | output | 1 | Underflow indication |
| inexact_o | output | 1 | Inexact indication |

## Verification
The assertions assume that the exponent input and the normalization shift stay inside the internal signed exponent range, and that out_ready_i behaves as an ordinary consumer that may stall at any time. They also rely on overflow and tiny results being mutually exclusive, which follows from the exponent thresholds. The stimulus keeps exponents within a few hundred of zero and always waits for a result before sending the next item, except in the stall scenario. That scenario deliberately holds out_ready_i low over several edges.

// File: rtl/fpnr_pkg.sv
package fpnr_pkg;
  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_ZERO = 2'b01,
    RND_UP   = 2'b10,
    RND_DOWN = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/fpnr_lzc.sv
// Binary-search leading-zero counter; each level keeps the half holding the first one.
module fpnr_lzc #(
  parameter int W   = 64,
  parameter int LVL = $clog2(W)
) (
  input  logic [W-1:0]   word_i,
  output logic [LVL-1:0] cnt_o,
  output logic           zero_o
);
  for (genvar k = 0; k < LVL; k++) begin : g_lvl
    localparam int HW = W >> (k + 1);
    logic [2*HW-1:0] win;
    logic [HW-1:0]   nxt;
    logic            hit;
    if (k == 0) begin : g_first
      assign win = word_i;
    end else begin : g_rest
      assign win = g_lvl[k-1].nxt;
    end
    assign hit = ~|win[2*HW-1:HW];
    assign nxt = hit ? win[HW-1:0] : win[2*HW-1:HW];
    assign cnt_o[LVL-1-k] = hit;
  end

  assign zero_o = (&cnt_o) & ~g_lvl[LVL-1].nxt[0];
endmodule

// File: rtl/fpnr_norm.sv
module fpnr_norm #(
  parameter int IN_EXP_W = 10,
  parameter int WORD_W   = 32,
  parameter int MANT_W   = 24,
  parameter int IE       = IN_EXP_W + 2
) (
  input  logic [IN_EXP_W-1:0] exp_i,
  input  logic [WORD_W-1:0]   frac_i,
  input  logic [WORD_W-1:0]   rem_i,
  output logic [IE-1:0]       exp_o,
  output logic [MANT_W-1:0]   mant_o,
  output logic [WORD_W-1:0]   rem_o,
  output logic                zero_o
);
  localparam int DW     = 2 * WORD_W;
  localparam int CW     = $clog2(DW);
  localparam int NW     = MANT_W + WORD_W;
  localparam int LEAD_Z = WORD_W - MANT_W;

  logic [DW-1:0] word;
  logic [CW-1:0] lz, lsh, rsh;
  logic [NW-1:0] w;
  logic          stk;
  logic signed [IE-1:0] exp_ext;

  assign word    = {frac_i, rem_i};
  assign exp_ext = {{(IE-IN_EXP_W){exp_i[IN_EXP_W-1]}}, exp_i};

  fpnr_lzc #(.W(DW)) u_lzc (
    .word_i (word),
    .cnt_o  (lz),
    .zero_o (zero_o)
  );

  always_comb begin
    lsh = '0;
    rsh = '0;
    stk = 1'b0;
    if (lz >= CW'(LEAD_Z)) begin
      lsh   = lz - CW'(LEAD_Z);
      w     = NW'(word << lsh);
      exp_o = exp_ext - IE'(lsh);
    end else begin
      rsh   = CW'(LEAD_Z) - lz;
      w     = NW'(word >> rsh);
      stk   = |(word & ~({DW{1'b1}} << rsh));
      exp_o = exp_ext + IE'(rsh);
    end
  end

  assign mant_o = w[NW-1:WORD_W];
  assign rem_o  = w[WORD_W-1:0] | {{(WORD_W-1){1'b0}}, stk};
endmodule

// File: rtl/fpnr_round.sv
module fpnr_round
  import fpnr_pkg::*;
#(
  parameter int MANT_W = 24,
  parameter int REM_W  = 32
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic [REM_W-1:0]  rem_i,
  input  logic              sign_i,
  input  rnd_mode_e         mode_i,
  output logic [MANT_W:0]   mant_o,
  output logic              inexact_o
);
  logic [REM_W:0] gsum;
  logic           inc, nz;

  always_comb begin
    nz   = |rem_i;
    gsum = {1'b0, rem_i} + {1'b0, 1'b1, {(REM_W-1){1'b0}}};
    unique case (mode_i)
      RND_NEAR: inc = gsum[REM_W];
      RND_ZERO: inc = 1'b0;
      RND_UP:   inc = nz & ~sign_i;
      RND_DOWN: inc = nz & sign_i;
      default:  inc = 1'b0;
    endcase
    mant_o = {1'b0, mant_i} + (MANT_W+1)'(inc);
    // exact half: result goes to the even neighbour
    if (mode_i == RND_NEAR && gsum[REM_W] && gsum[REM_W-1:0] == '0)
      mant_o[0] = 1'b0;
    inexact_o = nz;
  end
endmodule

// File: rtl/fp_norm_round.sv
module fp_norm_round
  import fpnr_pkg::*;
#(
  parameter int IN_EXP_W = 10,
  parameter int FRAC_W   = 23,
  parameter int EXP_BITS = 8,
  parameter int WORD_W   = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         in_valid_i,
  output logic                         in_ready_o,
  input  logic                         sign_i,
  input  logic [IN_EXP_W-1:0]          exp_i,
  input  logic [WORD_W-1:0]            frac_i,
  input  logic [WORD_W-1:0]            rem_i,
  input  logic [1:0]                   mode_i,
  output logic                         out_valid_o,
  input  logic                         out_ready_i,
  output logic [EXP_BITS+FRAC_W:0]     result_o,
  output logic                         overflow_o,
  output logic                         underflow_o,
  output logic                         inexact_o
);
  localparam int MANT_W = FRAC_W + 1;
  localparam int IE     = IN_EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_BITS - 1)) - 1;
  localparam int NW     = MANT_W + WORD_W;
  localparam int MAG_W  = EXP_BITS + FRAC_W;
  localparam int SWD    = $clog2(FRAC_W + 2);
  localparam logic signed [IE-1:0] EMAX_S = IE'(BIAS);
  localparam logic signed [IE-1:0] EMIN_S = IE'(1 - BIAS);
  localparam logic signed [IE-1:0] DEEP_S = IE'(FRAC_W + 2);
  localparam logic [EXP_BITS-1:0]  EXP_ONES = '1;

  // stage 1: normalize
  logic [IE-1:0]     n_exp;
  logic [MANT_W-1:0] n_mant;
  logic [WORD_W-1:0] n_rem;
  logic              n_zero, adv;

  fpnr_norm #(
    .IN_EXP_W (IN_EXP_W),
    .WORD_W   (WORD_W),
    .MANT_W   (MANT_W),
    .IE       (IE)
  ) u_norm (
    .exp_i  (exp_i),
    .frac_i (frac_i),
    .rem_i  (rem_i),
    .exp_o  (n_exp),
    .mant_o (n_mant),
    .rem_o  (n_rem),
    .zero_o (n_zero)
  );

  logic                 s1_valid, s1_sign, s1_zero;
  rnd_mode_e            s1_mode;
  logic signed [IE-1:0] s1_exp;
  logic [MANT_W-1:0]    s1_mant;
  logic [WORD_W-1:0]    s1_rem;

  assign adv        = ~out_valid_o | out_ready_i;
  assign in_ready_o = adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_sign  <= 1'b0;
      s1_zero  <= 1'b0;
      s1_mode  <= RND_NEAR;
      s1_exp   <= '0;
      s1_mant  <= '0;
      s1_rem   <= '0;
    end else if (adv) begin
      s1_valid <= in_valid_i;
      s1_sign  <= sign_i;
      s1_zero  <= n_zero;
      s1_mode  <= rnd_mode_e'(mode_i);
      s1_exp   <= n_exp;
      s1_mant  <= n_mant;
      s1_rem   <= n_rem;
    end
  end

  // stage 2: round, range check, denormalize, pack
  logic [MANT_W:0]      rn_mant, dn_mant;
  logic                 rn_inx, dn_inx;
  logic signed [IE-1:0] r_exp, dn;
  logic                 ovf, tiny, deep, to_inf, dir_hit;
  logic [SWD-1:0]       dsh;
  logic [NW-1:0]        full, shf;
  logic                 dstk;
  logic [MANT_W-1:0]    d_mant;
  logic [WORD_W-1:0]    d_rem;
  logic [MAG_W-1:0]     mag_n, res_mag;
  logic                 f_ovf, f_unf, f_inx;

  fpnr_round #(.MANT_W(MANT_W), .REM_W(WORD_W)) u_rnd_norm (
    .mant_i    (s1_mant),
    .rem_i     (s1_rem),
    .sign_i    (s1_sign),
    .mode_i    (s1_mode),
    .mant_o    (rn_mant),
    .inexact_o (rn_inx)
  );

  assign r_exp = s1_exp + IE'(rn_mant[MANT_W]);
  assign ovf   = r_exp > EMAX_S;
  assign tiny  = r_exp < EMIN_S;

  assign dn   = EMIN_S - s1_exp;
  assign deep = dn >= DEEP_S;
  assign dsh  = dn[SWD-1:0];
  assign full = {s1_mant, s1_rem};
  assign shf  = full >> dsh;
  assign dstk = |(full & ~({NW{1'b1}} << dsh));
  assign d_mant = shf[NW-1:WORD_W];
  assign d_rem  = shf[WORD_W-1:0] | {{(WORD_W-1){1'b0}}, dstk};

  fpnr_round #(.MANT_W(MANT_W), .REM_W(WORD_W)) u_rnd_dnrm (
    .mant_i    (d_mant),
    .rem_i     (d_rem),
    .sign_i    (s1_sign),
    .mode_i    (s1_mode),
    .mant_o    (dn_mant),
    .inexact_o (dn_inx)
  );

  // the hidden one (or a rounding carry) lands in the exponent field by addition
  assign mag_n = {EXP_BITS'(s1_exp + IE'(BIAS - 1)), {FRAC_W{1'b0}}} + MAG_W'(rn_mant);

  assign to_inf  = (s1_mode == RND_NEAR) | (s1_mode == RND_UP & ~s1_sign) |
                   (s1_mode == RND_DOWN & s1_sign);
  assign dir_hit = (s1_mode == RND_UP & ~s1_sign) | (s1_mode == RND_DOWN & s1_sign);

  always_comb begin
    res_mag = '0;
    f_ovf   = 1'b0;
    f_unf   = 1'b0;
    f_inx   = 1'b0;
    if (s1_zero) begin
      res_mag = '0;
    end else if (ovf) begin
      f_ovf   = 1'b1;
      f_inx   = 1'b1;
      res_mag = to_inf ? {EXP_ONES, {FRAC_W{1'b0}}}
                       : {EXP_ONES - 1'b1, {FRAC_W{1'b1}}};
    end else if (tiny) begin
      if (deep) begin
        res_mag = MAG_W'(dir_hit);
        f_unf   = 1'b1;
        f_inx   = 1'b1;
      end else begin
        res_mag = MAG_W'(dn_mant);
        f_unf   = dn_inx;
        f_inx   = dn_inx;
      end
    end else begin
      res_mag = mag_n;
      f_inx   = rn_inx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
      inexact_o   <= 1'b0;
    end else if (adv) begin
      out_valid_o <= s1_valid;
      if (s1_valid) begin
        result_o    <= {s1_sign, res_mag};
        overflow_o  <= f_ovf;
        underflow_o <= f_unf;
        inexact_o   <= f_inx;
      end
    end
  end
endmodule

// File: rtl/fp_norm_round_chk.sv
module fp_norm_round_chk #(
  parameter int FRAC_W   = 23,
  parameter int EXP_BITS = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     in_ready_o,
  input logic                     out_valid_o,
  input logic                     out_ready_i,
  input logic [EXP_BITS+FRAC_W:0] result_o,
  input logic                     overflow_o,
  input logic                     underflow_o,
  input logic                     inexact_o
);
  localparam int EHI = EXP_BITS + FRAC_W - 1;

  a_r7_ovf_inexact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && overflow_o |-> inexact_o);

  a_r7_ovf_exp_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && overflow_o |-> &result_o[EHI:FRAC_W+1]);

  a_r8_unf_small: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && underflow_o |-> result_o[EHI:FRAC_W+1] == '0 && inexact_o);

  a_r7_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !(overflow_o && underflow_o));

  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(result_o) &&
    $stable(overflow_o) && $stable(underflow_o) && $stable(inexact_o));

  a_r12_stall_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> out_valid_o && !out_ready_i);
endmodule

bind fp_norm_round fp_norm_round_chk #(
  .FRAC_W   (FRAC_W),
  .EXP_BITS (EXP_BITS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .result_o    (result_o),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o),
  .inexact_o   (inexact_o)
);

// File: tb/fp_norm_round_tb.sv
module fp_norm_round_tb;
  localparam logic [1:0] NE = 2'b00, TZ = 2'b01, UP = 2'b10, DN = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready, sgn = 1'b0;
  logic [9:0]  exp_in = '0;
  logic [31:0] frac = '0, rem = '0;
  logic [1:0]  mode = NE;
  logic        out_valid, out_ready = 1'b1;
  logic [31:0] res;
  logic        ovf, unf, inx;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  fp_norm_round u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .sign_i(sgn), .exp_i(exp_in), .frac_i(frac), .rem_i(rem), .mode_i(mode),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .result_o(res),
    .overflow_o(ovf), .underflow_o(unf), .inexact_o(inx)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 200000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [34:0] act, input logic [34:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h (result,ovf,unf,inx)", req, act, expv);
    end
  endtask

  task automatic tc(input string req, input logic s, input int e, input logic [31:0] f,
                    input logic [31:0] r, input logic [1:0] m, input logic [34:0] expv);
    logic [34:0] o;
    @(negedge clk);
    sgn = s; exp_in = 10'(e); frac = f; rem = r; mode = m;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    o = out_valid ? {res, ovf, unf, inx} : 'x;
    chk(req, o, expv);
  endtask

  task automatic t_reset;
    chk("R12 reset valid/ready", {33'd0, out_valid, in_ready}, {33'd0, 2'b01});
  endtask

  task automatic t_pack;
    tc("R10 one",          0,    0, 32'h0080_0000, 32'h0,  NE, {32'h3F80_0000, 3'b000});
    tc("R10 inexact flag", 0,    0, 32'h0080_0000, 32'h10, TZ, {32'h3F80_0000, 3'b001});
    tc("R10 min normal",   0, -126, 32'h0080_0000, 32'h0,  NE, {32'h0080_0000, 3'b000});
    tc("R10 max finite",   0,  127, 32'h00FF_FFFF, 32'h0,  NE, {32'h7F7F_FFFF, 3'b000});
  endtask

  task automatic t_left;
    tc("R1 frac lsb",      0, 0, 32'h0000_0001, 32'h0,          NE, {32'h3400_0000, 3'b000});
    tc("R1 rem only",      0, 0, 32'h0,         32'h0000_0001,  NE, {32'h2400_0000, 3'b000});
    tc("R1 rem msb",       0, 0, 32'h0,         32'h8000_0000,  NE, {32'h3380_0000, 3'b000});
    tc("R1 rem into frac", 0, 0, 32'h0000_0001, 32'hC000_0000,  NE, {32'h3460_0000, 3'b000});
  endtask

  task automatic t_right;
    tc("R2 shift 8",       0, 0, 32'h8000_0000, 32'h0,          NE, {32'h4380_0000, 3'b000});
    tc("R2 sticky kept",   0, 0, 32'h8000_0000, 32'h0000_0001,  NE, {32'h4380_0000, 3'b001});
    tc("R2 sticky rounds", 0, 0, 32'h0100_0001, 32'h0000_0001,  NE, {32'h4000_0001, 3'b001});
    tc("R2 out bits RZ",   0, 0, 32'h8000_00FF, 32'h0,          TZ, {32'h4380_0000, 3'b001});
    tc("R2 out bits RP",   0, 0, 32'h8000_00FF, 32'h0,          UP, {32'h4380_0001, 3'b001});
  endtask

  task automatic t_nearest;
    tc("R3 tie odd",   0, 0, 32'h0080_0001, 32'h8000_0000, NE, {32'h3F80_0002, 3'b001});
    tc("R3 tie even",  0, 0, 32'h0080_0002, 32'h8000_0000, NE, {32'h3F80_0002, 3'b001});
    tc("R3 above",     0, 0, 32'h0080_0002, 32'h8000_0001, NE, {32'h3F80_0003, 3'b001});
    tc("R3 below",     0, 0, 32'h0080_0001, 32'h7FFF_FFFF, NE, {32'h3F80_0001, 3'b001});
    tc("R3 shift tie", 0, 0, 32'h0100_0001, 32'h0,         NE, {32'h4000_0000, 3'b001});
  endtask

  task automatic t_directed;
    tc("R4 truncate", 1, 0, 32'h0080_0001, 32'hFFFF_FFFF, TZ, {32'hBF80_0001, 3'b001});
    tc("R5 up pos",   0, 0, 32'h0080_0000, 32'h1,         UP, {32'h3F80_0001, 3'b001});
    tc("R5 up neg",   1, 0, 32'h0080_0000, 32'h1,         UP, {32'hBF80_0000, 3'b001});
    tc("R5 down neg", 1, 0, 32'h0080_0000, 32'h1,         DN, {32'hBF80_0001, 3'b001});
    tc("R5 down pos", 0, 0, 32'h0080_0000, 32'h1,         DN, {32'h3F80_0000, 3'b001});
  endtask

  task automatic t_carry;
    tc("R6 carry RP",  0, 0, 32'h00FF_FFFF, 32'hFFFF_FFFF, UP, {32'h4000_0000, 3'b001});
    tc("R6 carry tie", 0, 0, 32'h00FF_FFFF, 32'h8000_0000, NE, {32'h4000_0000, 3'b001});
  endtask

  task automatic t_overflow;
    tc("R7 near pos", 0, 128, 32'h0080_0000, 32'h0, NE, {32'h7F80_0000, 3'b101});
    tc("R7 zero pos", 0, 128, 32'h0080_0000, 32'h0, TZ, {32'h7F7F_FFFF, 3'b101});
    tc("R7 zero neg", 1, 128, 32'h0080_0000, 32'h0, TZ, {32'hFF7F_FFFF, 3'b101});
    tc("R7 up pos",   0, 128, 32'h0080_0000, 32'h0, UP, {32'h7F80_0000, 3'b101});
    tc("R7 up neg",   1, 128, 32'h0080_0000, 32'h0, UP, {32'hFF7F_FFFF, 3'b101});
    tc("R7 down pos", 0, 128, 32'h0080_0000, 32'h0, DN, {32'h7F7F_FFFF, 3'b101});
    tc("R7 down neg", 1, 128, 32'h0080_0000, 32'h0, DN, {32'hFF80_0000, 3'b101});
    tc("R7 by round", 0, 127, 32'h00FF_FFFF, 32'h8000_0000, NE, {32'h7F80_0000, 3'b101});
  endtask

  task automatic t_tiny;
    tc("R8 exact denorm",  0, -127, 32'h0080_0000, 32'h0, NE, {32'h0040_0000, 3'b000});
    tc("R8 tie even",      0, -127, 32'h0080_0001, 32'h0, NE, {32'h0040_0000, 3'b011});
    tc("R8 tie up",        0, -127, 32'h0080_0003, 32'h0, NE, {32'h0040_0002, 3'b011});
    tc("R8 after round",   0, -127, 32'h00FF_FFFF, 32'h8000_0000, NE, {32'h0080_0000, 3'b001});
    tc("R8 reround carry", 0, -127, 32'h00FF_FFFF, 32'h0, NE, {32'h0080_0000, 3'b011});
    tc("R8 truncate",      0, -127, 32'h00FF_FFFF, 32'h0, TZ, {32'h007F_FFFF, 3'b011});
    tc("R8 up denorm",     0, -130, 32'h0080_0001, 32'h0, UP, {32'h0008_0001, 3'b011});
    tc("R8 shift 24 tie",  0, -150, 32'h0080_0000, 32'h0, NE, {32'h0000_0000, 3'b011});
    tc("R8 shift 24 up",   0, -150, 32'h0080_0001, 32'h0, NE, {32'h0000_0001, 3'b011});
  endtask

  task automatic t_deep;
    tc("R9 near",     0, -200, 32'h0080_0000, 32'h0, NE, {32'h0000_0000, 3'b011});
    tc("R9 up pos",   0, -200, 32'h0080_0000, 32'h0, UP, {32'h0000_0001, 3'b011});
    tc("R9 up neg",   1, -200, 32'h0080_0000, 32'h0, UP, {32'h8000_0000, 3'b011});
    tc("R9 down neg", 1, -200, 32'h0080_0000, 32'h0, DN, {32'h8000_0001, 3'b011});
    tc("R9 down pos", 0, -200, 32'h0080_0000, 32'h0, DN, {32'h0000_0000, 3'b011});
    tc("R9 zero neg", 1, -200, 32'h0080_0000, 32'h0, TZ, {32'h8000_0000, 3'b011});
    tc("R9 shift 25", 0, -151, 32'h00FF_FFFF, 32'hFFFF_FFFF, NE, {32'h0000_0000, 3'b011});
  endtask

  task automatic t_zero;
    tc("R11 neg zero",     1,    0, 32'h0, 32'h0, NE, {32'h8000_0000, 3'b000});
    tc("R11 zero deep RP", 0, -200, 32'h0, 32'h0, UP, {32'h0000_0000, 3'b000});
  endtask

  task automatic t_stall;
    logic [31:0] held;
    @(negedge clk);
    sgn = 0; exp_in = 10'd0; frac = 32'h0080_0000; rem = 32'h0; mode = NE;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R12 latency not early", {34'd0, out_valid}, 35'd0);
    @(negedge clk);
    chk("R12 valid after two edges", {res, out_valid, in_ready, 1'b0},
        {32'h3F80_0000, 3'b100});
    held = res;
    repeat (3) @(negedge clk);
    chk("R12 held while stalled", {res, out_valid, in_ready, 1'b0},
        {held, 3'b100});
    out_ready = 1'b1;
    @(negedge clk);
    chk("R12 drained", {33'd0, out_valid, in_ready}, {33'd0, 2'b01});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_pack();
    t_left();
    t_right();
    t_nearest();
    t_directed();
    t_carry();
    t_overflow();
    t_tiny();
    t_deep();
    t_zero();
    t_stall();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule